// File: doc/BRIEF.md
# Decoder Self-Test With Odd-Parity Response Check

This block wraps a binary-to-one-hot decoder with a built-in test. On a start request, a select counter steps through every input code, one per cycle. The decoder output for each code passes through a bit-level fault-injection stage and then reaches a checker that XOR-reduces the word. A healthy one-hot word has exactly one bit set, so the reduction is 1. Any word with an even number of set bits gives 0, including all zeros and two bits set, and is reported as a fault. No table of expected words is stored.

The wrapper keeps a fail flag that, once set, holds for the rest of the run and until the next start. It also latches the select code at which the first fault appeared. After the last code it pulses done, and it shows pass or fail until the next run begins. The stuck-low and stuck-high mask inputs exist only for verification: they force chosen decoder outputs to a fixed level before the checker sees them. Faults that leave an odd number of set bits pass unseen, and the bench shows this.

Top module: `dec_selftest`

## Requirements
- R1: After reset, busy_o, done_o, pass_o and fail_o are 0 and fail_code_o is 0.
- R2: A start_i seen while idle makes busy_o high for exactly 2^SEL_W (8) consecutive cycles, starting the cycle after. done_o is high for exactly one cycle, the first cycle after busy_o falls.
- R3: start_i while busy_o is high is ignored. The run neither restarts nor gets longer.
- R4: With no masks applied, the run ends with pass_o = 1 and fail_o = 0. pass_o and fail_o are never high together.
- R5: Bit k of stuck_lo_i forces decoder output k to 0. The word for code k then has no bits set, so the run fails with fail_code_o = k.
- R6: Bit j of stuck_hi_i forces decoder output j to 1 and has priority over stuck_lo_i. Every code other than j then gives two set bits, so fail_code_o is the lowest code not equal to j. All ones (eight bits, even) also fails.
- R7: Once fail_o rises during a run, it stays high and fail_code_o stays unchanged until the next accepted start. A later failing code does not overwrite the first one.
- R8: A word with an odd number of set bits is not flagged. With stuck_hi_i bits 5 and 6, codes 0 to 4 give three set bits and pass unseen, so fail_code_o = 5.
- R9: A start_i in the cycle where done_o is high is accepted. The next cycle shows busy_o = 1, and the previous pass_o and fail_o are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run when idle |
| stuck_lo_i | input | 8 | Per-output force-to-0 mask (verification only) |
| stuck_hi_i | input | 8 | Per-output force-to-1 mask, has priority (verification only) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at run end |
| pass_o | output | 1 | Last completed run found no fault |
| fail_o | output | 1 | A fault was seen in this or the last run |
| fail_code_o | output | 3 | Select code at the first failure |

## Verification
Two functions can fall in the same cycle. The end-of-run done pulse can coincide with a new start. The first-failure capture can also coincide with later failing codes in the same run, which must leave the captured code alone. The bench raises start_i in the done cycle after a failing run and checks that busy rises and the old verdict clears on the next edge. It also uses masks that fail at several codes (two stuck-low bits, all outputs stuck) and checks that fail_code_o holds the lowest failing code.

// File: rtl/dst_pkg.sv
package dst_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/dst_seq.sv
module dst_seq
  import dst_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             done_o,
  output logic [SEL_W-1:0] code_o
);
  localparam logic [SEL_W-1:0] CODE_MAX = '1;

  run_state_e       state_q;
  logic [SEL_W-1:0] cnt_q;
  logic             done_q;

  assign busy_o   = (state_q == ST_RUN);
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign last_o   = busy_o && (cnt_q == CODE_MAX);
  assign done_o   = done_q;
  assign code_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (cnt_q == CODE_MAX) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R2
  run_begins_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (busy_o && code_o == '0));

  // R3
  run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |=> (busy_o && code_o == $past(code_o) + 1'b1));
endmodule

// File: rtl/dst_decoder.sv
module dst_decoder #(
  parameter int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [OUT_W-1:0] hot_o
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    assign hot_o[i] = (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/dst_parity_chk.sv
module dst_parity_chk #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] stuck_lo_i,
  input  logic [WIDTH-1:0] stuck_hi_i,
  output logic [WIDTH-1:0] word_o,
  output logic             ok_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_inject
    assign word_o[i] = stuck_hi_i[i] | (raw_i[i] & ~stuck_lo_i[i]);
  end

  assign ok_o = ^word_o;
endmodule

// File: rtl/dec_selftest.sv
module dec_selftest #(
  parameter int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OUT_W-1:0] stuck_lo_i,
  input  logic [OUT_W-1:0] stuck_hi_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic [SEL_W-1:0] fail_code_o
);
  logic             accept;
  logic             last;
  logic [SEL_W-1:0] code;
  logic [OUT_W-1:0] dec_word;
  logic [OUT_W-1:0] chk_word;
  logic             word_ok;

  logic             fail_q;
  logic             valid_q;
  logic [SEL_W-1:0] code_q;

  dst_seq #(.SEL_W(SEL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .last_o   (last),
    .done_o   (done_o),
    .code_o   (code)
  );

  dst_decoder #(.SEL_W(SEL_W)) u_dec (
    .sel_i (code),
    .hot_o (dec_word)
  );

  // R5
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $onehot(dec_word));

  dst_parity_chk #(.WIDTH(OUT_W)) u_chk (
    .raw_i      (dec_word),
    .stuck_lo_i (stuck_lo_i),
    .stuck_hi_i (stuck_hi_i),
    .word_o     (chk_word),
    .ok_o       (word_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (accept) begin
      fail_q  <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (busy_o) begin
      if (!word_ok && !fail_q) begin
        fail_q <= 1'b1;
        code_q <= code;
      end
      if (last) valid_q <= 1'b1;
    end
  end

  assign fail_o      = fail_q;
  assign fail_code_o = code_q;
  assign pass_o      = valid_q & ~fail_q;

  // R5
  even_word_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ($countones(chk_word) % 2 == 0)) |=> fail_o);

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !accept) |=> fail_o);

  // R7
  first_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !accept) |=> $stable(fail_code_o));

  // R4
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));
endmodule

// File: tb/test_dec_selftest.sv
module test_dec_selftest;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] s_lo, s_hi;
  logic       busy, done, pass, fail;
  logic [2:0] fcode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dec_selftest i_dec_selftest (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .stuck_lo_i  (s_lo),
    .stuck_hi_i  (s_hi),
    .busy_o      (busy),
    .done_o      (done),
    .pass_o      (pass),
    .fail_o      (fail),
    .fail_code_o (fcode)
  );

  // {stuck_lo, stuck_hi, expect_fail, expect_code, requirement id}
  localparam logic [23:0] VEC [12] = '{
    {8'h00, 8'h00, 1'b0, 3'd0, 4'd4},
    {8'h01, 8'h00, 1'b1, 3'd0, 4'd5},
    {8'h80, 8'h00, 1'b1, 3'd7, 4'd5},
    {8'h10, 8'h00, 1'b1, 3'd4, 4'd5},
    {8'h00, 8'h01, 1'b1, 3'd1, 4'd6},
    {8'h00, 8'h08, 1'b1, 3'd0, 4'd6},
    {8'h00, 8'h60, 1'b1, 3'd5, 4'd8},
    {8'h00, 8'hC0, 1'b1, 3'd6, 4'd8},
    {8'h01, 8'h08, 1'b1, 3'd1, 4'd8},
    {8'h24, 8'h00, 1'b1, 3'd2, 4'd7},
    {8'h00, 8'hFF, 1'b1, 3'd0, 4'd6},
    {8'hFF, 8'h00, 1'b1, 3'd0, 4'd5}
  };

  function automatic string tag(input logic [3:0] id);
    case (id)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_once(input logic [7:0] lo, input logic [7:0] hi,
                          input logic efail, input logic [2:0] ecode,
                          input string req);
    bit seen = 0;
    s_lo = lo; s_hi = hi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 8; c++) begin
      check("R2", "busy during run", busy, 1);
      check("R2", "done during run", done, 0);
      if (seen) check("R7", "fail sticky mid-run", fail, 1);
      if (fail) seen = 1;
      @(negedge clk);
    end
    check("R2", "busy after run", busy, 0);
    check("R2", "done pulse", done, 1);
    check(req, "fail verdict", fail, efail);
    check("R4", "pass verdict", pass, !efail);
    if (efail) check(req, "first fail code", fcode, ecode);
    @(negedge clk);
    check("R2", "done single cycle", done, 0);
    check("R7", "fail held after run", fail, efail);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; s_lo = '0; s_hi = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "pass", pass, 0);
    check("R1", "fail", fail, 0);
    check("R1", "fail code", fcode, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      run_once(VEC[i][23:16], VEC[i][15:8], VEC[i][7], VEC[i][6:4],
               tag(VEC[i][3:0]));
    end

    // R3: start pulsed mid-run must not restart or stretch the run
    s_lo = '0; s_hi = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 8; c++) begin
      check("R3", "busy held", busy, 1);
      start = (c == 3);
      @(negedge clk);
    end
    start = 1'b0;
    check("R3", "done on time", done, 1);
    check("R3", "busy ended", busy, 0);
    @(negedge clk);
    check("R3", "no restart", busy, 0);

    // R9: failing run, then start in the done cycle
    s_lo = 8'h08;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check("R9", "done before restart", done, 1);
    check("R9", "failed run", fail, 1);
    check("R9", "failed code", fcode, 3);
    s_lo = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9", "restart busy", busy, 1);
    check("R9", "fail cleared", fail, 0);
    check("R9", "pass cleared", pass, 0);
    repeat (7) @(negedge clk);
    check("R9", "still busy at code 7", busy, 1);
    @(negedge clk);
    check("R9", "done after restart", done, 1);
    check("R9", "pass after restart", pass, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule